// File: doc/BRIEF.md
# Complementary Pair Transient Filter

This block turns one monitored object's pair of debounced line statuses into a single reported object state. The two lines carry the object's bit in complementary form: one line follows the bit and the other carries its inverse. Each line's debouncer delivers a 2-bit status giving a valid flag and a level. The block reports one of three states: passive, active or invalid. It also raises a one-cycle strobe whenever the reported state changes, so that a downstream transmitter knows to send a fresh value.

When both lines sit at the same level, the pair disagrees with itself. This normally happens briefly while the object switches over. During such a disagreement the block keeps reporting the last consistent state. It counts sample ticks for as long as the disagreement lasts. Once the count reaches a configurable limit, the object is declared invalid.

If either debouncer flags its line as invalid, the object is declared invalid at once. The object leaves the invalid state only when both lines are valid again and their levels disagree, which means the pair is consistent.

Top module: `pair_transient_filter`

## Requirements
- R1: A line status has bit 1 as the fault flag (1 = line invalid) and bit 0 as the level. The object state is coded 2'b00 passive, 2'b01 active and 2'b10 invalid.
- R2: A valid pair with the following line high and the inverse line low reports active. A valid pair with the following line low and the inverse line high reports passive. The new state shows on the clock edge that samples the pair.
- R3: While reset is low, and directly after it, the object state is passive and the strobe is low.
- R4: A pair at equal levels (both low or both high) that has seen fewer than MAX_TICKS sample ticks keeps the previously reported state.
- R5: The clock edge that samples the MAX_TICKS-th tick of an uninterrupted equal-level pair makes the state invalid. The state then stays invalid while the pair stays at equal levels.
- R6: Only cycles with the sample tick high advance the transient count. Any number of cycles without a tick leaves both the count and the state unchanged.
- R7: A consistent pair clears the transient count, so the next equal-level episode again gets the full MAX_TICKS budget.
- R8: A fault flag on either line makes the state invalid on the next edge, whether or not a tick is present.
- R9: The strobe is high for exactly the one cycle in which the reported state differs from the state of the cycle before. It is low at all other times.
- R10: Leaving invalid requires both lines valid and at opposite levels. A change from active to passive through an equal-level episode shorter than MAX_TICKS ticks reports the new state without passing through invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | One-cycle pulse for each input sample period |
| follow_st | input | 2 | Debounced status of the line that follows the bit (bit 1 fault, bit 0 level) |
| inverse_st | input | 2 | Debounced status of the line that carries the inverted bit |
| obj_state | output | 2 | Reported object state: 00 passive, 01 active, 10 invalid |
| obj_change | output | 1 | One-cycle strobe when obj_state changes |

## Verification
Most internal faults show at the ports within one clock edge. A wrong classification of the pair shows as the wrong obj_state on the edge after the inputs are applied. A strobe that is lost or spurious appears in the same cycle as the state update. A transient counter that fails to clear, that counts cycles without a tick, or that has an off-by-one limit stays hidden until an equal-level episode runs its course. It then shows as invalid arriving one tick early or late, or as a second episode that expires too soon. The bench therefore sweeps every transient length from zero to past the limit, with idle cycles between ticks, from both starting states and into both ending states. It also applies all sixteen status combinations from each valid state.

// File: rtl/ptf_pkg.sv
// Package: shared types of the complementary pair transient filter.
// Assumes: a line status is {fault, level}; state codes are seen at the top ports.
package ptf_pkg;

    // Reported object state (encoding is visible at the top port)
    typedef enum logic [1:0] {
        OBJ_PASSIVE = 2'b00,
        OBJ_ACTIVE  = 2'b01,
        OBJ_INVALID = 2'b10
    } obj_state_e;

    // Classification of one sampled pair
    typedef enum logic [1:0] {
        PAIR_PASSIVE  = 2'b00,
        PAIR_ACTIVE   = 2'b01,
        PAIR_CONFLICT = 2'b10,
        PAIR_FAULT    = 2'b11
    } pair_kind_e;

    // Bit positions inside a line status
    localparam int STAT_FAULT_BIT = 1;
    localparam int STAT_LEVEL_BIT = 0;
    localparam int STAT_W         = 2;

endpackage

// File: rtl/ptf_pair_classifier.sv
// Module: ptf_pair_classifier
// Purpose: combinational sorting of the two line statuses into one pair kind.
// Assumes: statuses are already debounced; a fault on either line dominates.
module ptf_pair_classifier
    import ptf_pkg::*;
(
    input  logic [STAT_W-1:0] follow_st,
    input  logic [STAT_W-1:0] inverse_st,
    output pair_kind_e        kind
);

    logic any_fault;
    logic lvl_follow;
    logic lvl_inverse;

    assign any_fault   = follow_st[STAT_FAULT_BIT] | inverse_st[STAT_FAULT_BIT];
    assign lvl_follow  = follow_st[STAT_LEVEL_BIT];
    assign lvl_inverse = inverse_st[STAT_LEVEL_BIT];

    // Sort the pair: fault first, then equal levels, then the consistent level
    always_comb begin
        if (any_fault) begin
            kind = PAIR_FAULT;
        end else if (lvl_follow == lvl_inverse) begin
            kind = PAIR_CONFLICT;
        end else if (lvl_follow) begin
            kind = PAIR_ACTIVE;
        end else begin
            kind = PAIR_PASSIVE;
        end
    end

endmodule

// File: rtl/ptf_transient_timer.sv
// Module: ptf_transient_timer
// Purpose: counts sample ticks during an equal-level episode and flags expiry.
// Assumes: MAX_TICKS >= 1; the count saturates at MAX_TICKS and clears on any
// cycle without a conflict.
module ptf_transient_timer #(
    parameter int MAX_TICKS = 29
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conflict,
    input  logic tick,
    output logic limit_hit
);

    localparam int CNT_W = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(MAX_TICKS);
    localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(MAX_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Tick counter: clear outside a conflict, step on ticks, saturate at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!conflict) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry: already saturated, or this tick is the one that reaches the limit
    assign limit_hit = conflict && ((cnt_q == LIMIT) || (tick && (cnt_q == LIMIT_M1)));

    a_r7_clear_on_consistent : assert property (@(posedge clk) disable iff (!rst_n)
        !conflict |=> (cnt_q == '0));

    a_r6_idle_cycle_holds : assert property (@(posedge clk) disable iff (!rst_n)
        (conflict && !tick) |=> $stable(cnt_q));

    a_r5_count_bounded : assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

endmodule

// File: rtl/ptf_state_holder.sv
// Module: ptf_state_holder
// Purpose: holds the reported object state and produces the change strobe.
// Assumes: the kind and limit_hit inputs are valid every cycle; reset state is passive.
module ptf_state_holder
    import ptf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pair_kind_e kind,
    input  logic       limit_hit,
    output obj_state_e state,
    output logic       strobe
);

    obj_state_e nxt;

    // Next state: consistent pairs set the level, faults force invalid, conflicts hold until expiry
    always_comb begin
        case (kind)
            PAIR_ACTIVE:   nxt = OBJ_ACTIVE;
            PAIR_PASSIVE:  nxt = OBJ_PASSIVE;
            PAIR_FAULT:    nxt = OBJ_INVALID;
            default:       nxt = limit_hit ? OBJ_INVALID : state;
        endcase
    end

    // State and strobe registers, updated together so the strobe marks the new value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= OBJ_PASSIVE;
            strobe <= 1'b0;
        end else begin
            state  <= nxt;
            strobe <= (nxt != state);
        end
    end

    a_r8_fault_forces_invalid : assert property (@(posedge clk) disable iff (!rst_n)
        (kind == PAIR_FAULT) |=> (state == OBJ_INVALID));

    a_r4_conflict_holds : assert property (@(posedge clk) disable iff (!rst_n)
        (kind == PAIR_CONFLICT && !limit_hit) |=> $stable(state));

    a_r9_strobe_on_change : assert property (@(posedge clk) disable iff (!rst_n)
        (state != $past(state)) |-> strobe);

    a_r9_strobe_only_on_change : assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (state != $past(state)));

endmodule

// File: rtl/pair_transient_filter.sv
// Module: pair_transient_filter (top)
// Purpose: merges two complementary debounced line statuses into one object
// state, masking equal-level transients for up to MAX_TICKS sample ticks.
// Assumes: sample_tick is a one-cycle pulse; statuses use {fault, level}.
module pair_transient_filter
    import ptf_pkg::*;
#(
    parameter int MAX_TICKS = 29
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_tick,
    input  logic [1:0] follow_st,
    input  logic [1:0] inverse_st,
    output logic [1:0] obj_state,
    output logic       obj_change
);

    pair_kind_e kind;
    logic       limit_hit;
    obj_state_e state_q;

    ptf_pair_classifier u_classify (
        .follow_st  (follow_st),
        .inverse_st (inverse_st),
        .kind       (kind)
    );

    ptf_transient_timer #(
        .MAX_TICKS (MAX_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .conflict  (kind == PAIR_CONFLICT),
        .tick      (sample_tick),
        .limit_hit (limit_hit)
    );

    ptf_state_holder u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .limit_hit (limit_hit),
        .state     (state_q),
        .strobe    (obj_change)
    );

    assign obj_state = state_q;

    a_r2_follows_consistent_pair : assert property (@(posedge clk) disable iff (!rst_n)
        (!follow_st[1] && !inverse_st[1] && (follow_st[0] != inverse_st[0]))
        |=> (obj_state == {1'b0, $past(follow_st[0])}));

    a_r1_legal_code : assert property (@(posedge clk) disable iff (!rst_n)
        obj_state != 2'b11);

endmodule

// File: tb/pair_transient_filter_tb_top.sv
`timescale 1ns/1ps
module pair_transient_filter_tb_top;

    localparam int LIM = 4;
    localparam logic [1:0] LO  = 2'b00;
    localparam logic [1:0] HI  = 2'b01;
    localparam logic [1:0] S_PAS = 2'b00;
    localparam logic [1:0] S_ACT = 2'b01;
    localparam logic [1:0] S_INV = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] f_st = LO;
    logic [1:0] i_st = HI;
    logic [1:0] st;
    logic       stb;
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pair_transient_filter #(.MAX_TICKS(LIM)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (tick),
        .follow_st   (f_st),
        .inverse_st  (i_st),
        .obj_state   (st),
        .obj_change  (stb)
    );

    task automatic chk(input string req, input logic [1:0] e_st, input logic e_stb);
        n_run++;
        if (st !== e_st || stb !== e_stb) begin
            n_fail++;
            $display("FAIL %s: state=%b strobe=%b expected state=%b strobe=%b",
                     req, st, stb, e_st, e_stb);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic step(input logic [1:0] f, input logic [1:0] i, input logic t);
        f_st = f; i_st = i; tick = t;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // Consistent pair for a valid state
    task automatic drive_state(input logic [1:0] s);
        if (s == S_ACT) step(HI, LO, 1'b0); else step(LO, HI, 1'b0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0] prev;
        logic [1:0] e;
        @(negedge clk);
        // R3: reset holds passive even with an active pair present
        f_st = HI; i_st = LO;
        repeat (3) @(negedge clk);
        chk("R3 during reset", S_PAS, 1'b0);
        step(LO, HI, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 after reset", S_PAS, 1'b0);
        // R2: active then passive
        step(HI, LO, 1'b0);
        chk("R2 active", S_ACT, 1'b1);
        step(LO, HI, 1'b0);
        chk("R2 passive", S_PAS, 1'b1);

        // Transient sweep: R4 R5 R6 R9 R10
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 2; c++) begin
                for (int k = 0; k <= LIM + 1; k++) begin
                    for (int en = 0; en < 2; en++) begin
                        logic [1:0] cf;
                        cf = (c == 0) ? LO : HI;
                        drive_state(2'(s));
                        drive_state(2'(s));
                        chk("R2 start state", 2'(s), 1'b0);
                        prev = 2'(s);
                        for (int j = 1; j <= k; j++) begin
                            step(cf, cf, 1'b1);
                            e = (j >= LIM) ? S_INV : 2'(s);
                            chk((j >= LIM) ? "R5 expiry" : "R4 masked", e, (j == LIM));
                            step(cf, cf, 1'b0);
                            chk("R6 idle cycle", e, 1'b0);
                            prev = e;
                        end
                        drive_state(2'(en));
                        chk("R10 leave transient", 2'(en), (2'(en) != prev));
                    end
                end
            end
        end

        // R7: a consistent cycle restores the full budget
        drive_state(S_ACT);
        drive_state(S_ACT);
        for (int j = 0; j < LIM - 1; j++) step(HI, HI, 1'b1);
        chk("R7 first episode", S_ACT, 1'b0);
        drive_state(S_ACT);
        for (int j = 0; j < LIM - 1; j++) step(LO, LO, 1'b1);
        chk("R7 second episode full budget", S_ACT, 1'b0);
        step(LO, LO, 1'b1);
        chk("R7 second episode expiry", S_INV, 1'b1);
        // R10: staying at equal levels keeps invalid; fault plus level does not recover
        repeat (3) step(LO, LO, 1'b1);
        chk("R10 stays invalid", S_INV, 1'b0);
        step(2'b11, LO, 1'b0);
        chk("R10 fault blocks recovery", S_INV, 1'b0);
        drive_state(S_PAS);
        chk("R10 recovery", S_PAS, 1'b1);

        // R8 R1: every status combination from each valid state
        for (int s = 0; s < 2; s++) begin
            for (int f = 0; f < 4; f++) begin
                for (int i = 0; i < 4; i++) begin
                    logic [1:0] fv;
                    logic [1:0] iv;
                    fv = 2'(f); iv = 2'(i);
                    drive_state(2'(s));
                    drive_state(2'(s));
                    if (fv[1] || iv[1])       e = S_INV;
                    else if (fv[0] != iv[0])  e = {1'b0, fv[0]};
                    else                      e = 2'(s);
                    step(fv, iv, 1'b0);
                    chk((fv[1] || iv[1]) ? "R8 fault" : "R1 coding", e, (e != 2'(s)));
                    drive_state(2'(s));
                    chk("R9 return strobe", 2'(s), (e != 2'(s)));
                end
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule